// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable synchronous counter of parameterised width. A parameter selects its counting range: the full binary range of the register, or a decade range of 0 to 9. Every state bit updates on the same rising clock edge. On each edge the counter either loads a parallel value, steps up or down by one, or holds its value. These choices depend only on the control inputs sampled at that edge.

Two active-low enables both have to be asserted for a step to happen. Only the second enable also gates the active-low terminal-count output. When the terminal-count output of one stage drives the second enable of the next stage, the stages form a wider synchronous counter with no extra gates between them. The load input has priority over counting. This allows a stage to be reloaded from its neighbour's terminal-count signal.

Top module: `updn_cascade_counter`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `count` becomes 0 after that edge. Reset has priority over load and counting.
- R2: With `load_n` low at a rising edge, `count` takes the value of `data_in` after that edge, whatever the enables and direction are.
- R3: With `load_n` high and either `en_p_n` or `en_t_n` high at a rising edge, `count` keeps its value across that edge.
- R4: With `load_n`, `en_p_n` and `en_t_n` all low at an edge, `count` goes up by one when `up` is 1 and down by one when `up` is 0.
- R5: The top count is 15 when `DECADE` is 0 and 9 when `DECADE` is 1. Stepping up from the top count gives 0, and stepping down from 0 gives the top count.
- R6: `carry_n` is 0 only when `en_t_n` is 0 and the count is at its terminal value for the current direction: the top count when `up` is 1, or 0 when `up` is 0. `en_p_n` has no effect on `carry_n`.
- R7: `carry_n` is combinational. A change on `up` or `en_t_n` shows on `carry_n` with no clock edge.
- R8: In decade mode, a loaded value from 10 to 15 steps up with 4-bit wrap-around (12 to 13, 15 to 0) and steps down by one (10 to 9).
- R9: Three stages chained through `carry_n` into the next `en_t_n`, sharing the other controls, count as one 12-bit binary counter or as one 3-digit decimal counter, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | WIDTH | Value to load |
| en_p_n | input | 1 | Count enable that does not affect the carry, active low |
| en_t_n | input | 1 | Count enable that also gates the carry, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal-count output, active low |

## Verification
The bench drives a binary instance and a decade instance with the same stimulus. It compares both against a model built from the requirements on every edge.

The corner cases it targets are these:
- Wrap-around at the mode's top count in both directions. A design with the wrong top value would run a decade stage through 10 to 15.
- Load asserted while both enables are low. A design with the wrong priority would step instead of load.
- A direction change on a terminal count with no clock edge. A registered carry would lag by one cycle.
- Decade stages loaded with 10 to 15, which must leave that range in the stated way.

Three-stage chains in both modes cross digit and nibble boundaries upward and downward. A carry gated by the wrong enable, or one that ignores direction, makes the upper stages skip or double-step.

// File: rtl/ucc_pkg.sv
// Shared types for the cascadable up/down counter.
// Assumes: included first in compile order.
package ucc_pkg;
    // Operation chosen for the next clock edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } ucc_op_e;
endpackage

// File: rtl/ucc_mode_sel.sv
// Decodes the control inputs into one operation for the next edge.
// Load beats counting; counting needs both active-low enables low.
// Assumes: inputs are stable around the rising clock edge.
module ucc_mode_sel (
    input  logic              load_n,
    input  logic              en_p_n,
    input  logic              en_t_n,
    input  logic              up,
    output ucc_pkg::ucc_op_e  op
);
    import ucc_pkg::*;

    // Priority decode: load, then count, else hold.
    always_comb begin
        if (!load_n)                  op = OP_LOAD;
        else if (en_p_n || en_t_n)    op = OP_HOLD;
        else if (up)                  op = OP_INC;
        else                          op = OP_DEC;
    end
endmodule

// File: rtl/ucc_step.sv
// Computes the next count from the current count and the operation.
// DECADE selects a wrap at 9; otherwise the register wraps naturally.
// Assumes: WIDTH >= 4 when DECADE is set.
module ucc_step #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  ucc_pkg::ucc_op_e   op,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   data,
    output logic [WIDTH-1:0]   nxt
);
    import ucc_pkg::*;

    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    logic [WIDTH-1:0] inc_v;
    logic [WIDTH-1:0] dec_v;

    generate
        if (DECADE) begin : g_decade
            // Explicit wrap at the decade top; out-of-range values use plain arithmetic.
            assign inc_v = (cur == TOP)      ? '0  : cur + WIDTH'(1);
            assign dec_v = (cur == '0)       ? TOP : cur - WIDTH'(1);
        end else begin : g_binary
            // Full-range counter: natural modulo wrap of the register.
            assign inc_v = cur + WIDTH'(1);
            assign dec_v = cur - WIDTH'(1);
        end
    endgenerate

    // Select the next value for the chosen operation.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = data;
            OP_INC:  nxt = inc_v;
            OP_DEC:  nxt = dec_v;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ucc_term.sv
// Active-low terminal-count detector used to chain stages.
// Low when the carry enable is low and the count sits at the end of its
// range for the current direction.
// Assumes: purely combinational; the consumer samples it at the clock edge.
module ucc_term #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up,
    input  logic             en_t_n,
    output logic             carry_n
);
    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    logic at_end;

    // Terminal value depends on direction; gate with the carry enable.
    always_comb begin
        at_end  = up ? (cur == TOP) : (cur == '0);
        carry_n = !(at_end && !en_t_n);
    end
endmodule

// File: rtl/updn_cascade_counter.sv
// Top of the cascadable synchronous up/down counter.
// One state register. The next state comes from the mode decoder and the
// step logic, and the carry is derived combinationally from the state.
// Assumes: a single clock; rst_n is synchronous and active low.
module updn_cascade_counter #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic             en_p_n,
    input  logic             en_t_n,
    input  logic             up,
    output logic [WIDTH-1:0] count,
    output logic             carry_n
);
    import ucc_pkg::*;

    ucc_op_e          op;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    ucc_mode_sel u_mode (
        .load_n (load_n),
        .en_p_n (en_p_n),
        .en_t_n (en_t_n),
        .up     (up),
        .op     (op)
    );

    ucc_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
        .op   (op),
        .cur  (cnt_q),
        .data (data_in),
        .nxt  (cnt_d)
    );

    ucc_term #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
        .cur     (cnt_q),
        .up      (up),
        .en_t_n  (en_t_n),
        .carry_n (carry_n)
    );

    // State register: all bits update on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ucc_checker.sv
// Property checker for updn_cascade_counter, attached with bind.
// Assumes: the same WIDTH and DECADE as the bound instance.
module ucc_checker #(
    parameter int WIDTH  = 4,
    parameter bit DECADE = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_n,
    input logic [WIDTH-1:0] data_in,
    input logic             en_p_n,
    input logic             en_t_n,
    input logic             up,
    input logic [WIDTH-1:0] count,
    input logic             carry_n
);
    localparam logic [WIDTH-1:0] TOP = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

    // R1: reset clears the count
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> count == '0);

    // R2: load copies data
    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(data_in));

    // R3: any enable high holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (en_p_n || en_t_n)) |=> $stable(count));

    // R4: step up by one away from the top
    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && up && count != TOP)
        |=> count == WIDTH'($past(count) + WIDTH'(1)));

    // R4: step down by one away from zero
    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && !up && count != '0)
        |=> count == WIDTH'($past(count) - WIDTH'(1)));

    // R5: wrap at the top going up
    p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && up && count == TOP) |=> count == '0);

    // R5: wrap at zero going down
    p_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && !up && count == '0) |=> count == TOP);

    // R6: carry is blocked while the carry enable is high
    p_carry_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_t_n |-> carry_n);

    // R6: carry only at a range end
    p_carry_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == '0 || count == TOP));
endmodule

bind updn_cascade_counter ucc_checker #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .data_in (data_in),
    .en_p_n  (en_p_n),
    .en_t_n  (en_t_n),
    .up      (up),
    .count   (count),
    .carry_n (carry_n)
);

// File: tb/tb_updn_cascade_counter.sv
// Directed bench: a binary and a decade counter share stimulus; two
// three-stage chains (one per mode) check cascading against wide models.
module tb_updn_cascade_counter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst_n, load_n, en_p_n, en_t_n, up;
    logic [3:0] data;
    logic [3:0] q_b, q_d;
    logic       co_b, co_d;

    logic        c_load_n, c_up, c_ep_n, c_en_n;
    logic [11:0] c_bdata, c_ddata;
    logic [11:0] cq_b, cq_d;
    logic [2:0]  cet_b, cet_d, cco_b, cco_d;

    int checks = 0;
    int fails  = 0;
    logic [3:0] mb, md;
    int wb, wd;

    updn_cascade_counter #(.WIDTH(4), .DECADE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .data_in(data),
        .en_p_n(en_p_n), .en_t_n(en_t_n), .up(up), .count(q_b), .carry_n(co_b));

    updn_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) dut_dec (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .data_in(data),
        .en_p_n(en_p_n), .en_t_n(en_t_n), .up(up), .count(q_d), .carry_n(co_d));

    for (genvar k = 0; k < 3; k++) begin : g_chain
        if (k == 0) begin : g_first
            assign cet_b[k] = c_en_n;
            assign cet_d[k] = c_en_n;
        end else begin : g_next
            assign cet_b[k] = cco_b[k-1];
            assign cet_d[k] = cco_d[k-1];
        end
        updn_cascade_counter #(.WIDTH(4), .DECADE(1'b0)) u_b (
            .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .data_in(c_bdata[4*k +: 4]),
            .en_p_n(c_ep_n), .en_t_n(cet_b[k]), .up(c_up),
            .count(cq_b[4*k +: 4]), .carry_n(cco_b[k]));
        updn_cascade_counter #(.WIDTH(4), .DECADE(1'b1)) u_d (
            .clk(clk), .rst_n(rst_n), .load_n(c_load_n), .data_in(c_ddata[4*k +: 4]),
            .en_p_n(c_ep_n), .en_t_n(cet_d[k]), .up(c_up),
            .count(cq_d[4*k +: 4]), .carry_n(cco_d[k]));
    end

    // Reference next count (R2..R5, R8).
    function automatic logic [3:0] f_next(logic [3:0] c, logic [3:0] top);
        if (!load_n)              return data;
        if (en_p_n || en_t_n)     return c;
        if (up)                   return (c == top) ? 4'd0 : 4'(c + 4'd1);
        return (c == 4'd0) ? top : 4'(c - 4'd1);
    endfunction

    // Reference carry (R6).
    function automatic logic f_carry(logic [3:0] c, logic [3:0] top);
        return !(!en_t_n && (up ? (c == top) : (c == 4'd0)));
    endfunction

    function automatic int bcd3(logic [11:0] v);
        return int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock edge with model update and full comparison.
    task automatic step(string tag);
        logic [3:0] nb, nd;
        int nwb, nwd;
        if (!rst_n) begin
            nb = 4'd0; nd = 4'd0; nwb = 0; nwd = 0;
        end else begin
            nb = f_next(mb, 4'd15);
            nd = f_next(md, 4'd9);
            if (!c_load_n) begin
                nwb = int'(c_bdata); nwd = bcd3(c_ddata);
            end else if (!c_ep_n && !c_en_n) begin
                nwb = c_up ? (wb + 1) % 4096 : (wb + 4095) % 4096;
                nwd = c_up ? (wd + 1) % 1000 : (wd + 999) % 1000;
            end else begin
                nwb = wb; nwd = wd;
            end
        end
        @(posedge clk);
        #1;
        mb = nb; md = nd; wb = nwb; wd = nwd;
        check(tag, "binary count", 32'(q_b), 32'(mb));
        check(tag, "decade count", 32'(q_d), 32'(md));
        check(tag, "binary carry", 32'(co_b), 32'(f_carry(mb, 4'd15)));
        check(tag, "decade carry", 32'(co_d), 32'(f_carry(md, 4'd9)));
        check(tag, "binary chain", 32'(cq_b), 32'(wb));
        check(tag, "decade chain", 32'(bcd3(cq_d)), 32'(wd));
    endtask

    task automatic load_both(logic [3:0] v, string tag);
        load_n = 1'b0; data = v; step(tag); load_n = 1'b1;
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0; step("R1"); step("R1");
        check("R1", "reset binary", 32'(q_b), 32'd0);
        rst_n = 1'b1;
        load_both(4'd5, "R1");
        rst_n = 1'b0; load_n = 1'b0; en_p_n = 1'b0; en_t_n = 1'b0;
        step("R1");
        check("R1", "reset beats load", 32'(q_b), 32'd0);
        rst_n = 1'b1; load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1;
    endtask

    task automatic t_load_r2();
        en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1;
        load_n = 1'b0; data = 4'd7; step("R2");
        check("R2", "load beats count", 32'(q_d), 32'd7);
        data = 4'd2; up = 1'b0; step("R2");
        load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1;
    endtask

    task automatic t_hold_r3();
        load_both(4'd4, "R3");
        en_p_n = 1'b1; en_t_n = 1'b0; up = 1'b1; step("R3"); step("R3");
        en_p_n = 1'b0; en_t_n = 1'b1; step("R3");
        en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b0; step("R3");
        check("R3", "held value", 32'(q_b), 32'd4);
    endtask

    task automatic t_count_r4();
        load_both(4'd3, "R4");
        en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1;
        for (int i = 0; i < 4; i++) step("R4");
        up = 1'b0;
        for (int i = 0; i < 6; i++) step("R4");
        en_p_n = 1'b1; en_t_n = 1'b1;
    endtask

    task automatic t_wrap_r5();
        load_both(4'd9, "R5");
        en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1; step("R5");
        check("R5", "decade wrap up", 32'(q_d), 32'd0);
        load_both(4'd15, "R5"); step("R5");
        check("R5", "binary wrap up", 32'(q_b), 32'd0);
        load_both(4'd0, "R5"); up = 1'b0; step("R5");
        check("R5", "binary wrap down", 32'(q_b), 32'd15);
        check("R5", "decade wrap down", 32'(q_d), 32'd9);
        en_p_n = 1'b1; en_t_n = 1'b1;
    endtask

    task automatic t_carry_r6_r7();
        en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b1;
        load_both(4'd15, "R6");
        en_t_n = 1'b0; #1;
        check("R6", "binary carry at top", 32'(co_b), 32'd0);
        check("R6", "decade carry off at 15", 32'(co_d), 32'd1);
        en_p_n = 1'b0; #1;
        check("R6", "p enable ignored by carry", 32'(co_b), 32'd0);
        en_p_n = 1'b1;
        en_t_n = 1'b1; #1;
        check("R7", "carry drops with t enable", 32'(co_b), 32'd1);
        en_t_n = 1'b0; up = 1'b0; #1;
        check("R7", "carry follows direction", 32'(co_b), 32'd1);
        up = 1'b1; #1;
        check("R7", "carry back on direction", 32'(co_b), 32'd0);
        load_both(4'd0, "R6");
        up = 1'b0; #1;
        check("R6", "binary carry at zero down", 32'(co_b), 32'd0);
        check("R6", "decade carry at zero down", 32'(co_d), 32'd0);
        load_both(4'd9, "R6");
        up = 1'b1; #1;
        check("R6", "decade carry at nine", 32'(co_d), 32'd0);
        check("R6", "binary no carry at nine", 32'(co_b), 32'd1);
        en_t_n = 1'b1;
    endtask

    task automatic t_decade_range_r8();
        load_both(4'd12, "R8");
        en_p_n = 1'b0; en_t_n = 1'b0; up = 1'b1; step("R8");
        check("R8", "12 steps to 13", 32'(q_d), 32'd13);
        step("R8"); step("R8"); step("R8");
        check("R8", "15 wraps to 0", 32'(q_d), 32'd0);
        load_both(4'd10, "R8"); up = 1'b0; step("R8");
        check("R8", "10 steps down to 9", 32'(q_d), 32'd9);
        en_p_n = 1'b1; en_t_n = 1'b1;
    endtask

    task automatic t_cascade_r9();
        c_ep_n = 1'b0; c_en_n = 1'b0; c_up = 1'b1;
        c_load_n = 1'b0; c_bdata = 12'hFFC; c_ddata = 12'h997; step("R9");
        c_load_n = 1'b1;
        for (int i = 0; i < 6; i++) step("R9");
        c_up = 1'b0;
        for (int i = 0; i < 10; i++) step("R9");
        c_load_n = 1'b0; c_bdata = 12'h101; c_ddata = 12'h101; step("R9");
        c_load_n = 1'b1;
        for (int i = 0; i < 4; i++) step("R9");
        c_load_n = 1'b0; c_bdata = 12'h010; c_ddata = 12'h010; step("R9");
        c_load_n = 1'b1; c_up = 1'b1;
        for (int i = 0; i < 60; i++) begin
            c_ep_n = (i % 7 == 3);
            c_en_n = (i % 11 == 5);
            if (i == 30) c_up = 1'b0;
            step("R9");
        end
        c_ep_n = 1'b1; c_en_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; load_n = 1'b1; en_p_n = 1'b1; en_t_n = 1'b1; up = 1'b1; data = 4'd0;
        c_load_n = 1'b1; c_ep_n = 1'b1; c_en_n = 1'b1; c_up = 1'b1;
        c_bdata = 12'd0; c_ddata = 12'd0;
        #(CLK_PERIOD/2 + 1);
        t_reset_r1();
        t_load_r2();
        t_hold_r3();
        t_count_r4();
        t_wrap_r5();
        t_carry_r6_r7();
        t_decade_range_r8();
        t_cascade_r9();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule